// File: doc/BRIEF.md
# Eight-pin GPIO port register block with masked write aliases

This block holds the control state of one eight-pin general-purpose I/O port and sits behind a simple 32-bit register bus. Per pin it keeps a mode bit, an output-enable bit and an output value bit. A mode bit of 1 gives the pin to software. A mode bit of 0 leaves the pad with the alternate-function source. The block also holds a read-only input register, filled by a two-stage synchronizer on each pad input.

Every writable register has two write addresses. The plain address loads all eight bits from write-data bits 7:0. The masked alias treats write-data bits 15:8 as per-pin write enables and bits 7:0 as the new values. Software can then change any subset of pins in one bus write, with no read-modify-write.

Four ports make a 32-pin bank, at word offsets 0, 4, 8 and 12. The parameter `PORT_IDX` places this port among them. The masked aliases sit at `MASK_OFS` above the plain addresses. Reads are registered and return data one clock after the read strobe.

Top module: `gpx_port`

## Requirements
- R1: While `rst` is high, the mode, output-enable and output registers clear to 0, and so does `bus_rdata`. The first reads after reset return 0 for all three registers.
- R2: With base B = `PORT_IDX`*4, a write to B+0x00 (mode), B+0x10 (output enable) or B+0x20 (output value) loads write-data bits 7:0 into that register. Write-data bits 31:8 have no effect.
- R3: With M = `MASK_OFS` + B, a write to M+0x00, M+0x10 or M+0x20 sets bit n of the matching register to write-data bit n when write-data bit n+8 is 1. A bit whose enable is 0 keeps its value.
- R4: A masked write whose bits 15:8 are all zero changes no register.
- R5: When `bus_rd` is high at a clock edge, `bus_rdata` holds the addressed register in bits 7:0 from that edge onwards. Bits 31:8 are always zero. A read at a masked alias returns the same register as the plain address.
- R6: A read at B+0x30 returns `pad_in` through two flops. A pad change made before clock edge k shows in reads captured at edge k+2 and later, but not in reads captured at edges k or k+1.
- R7: A write to B+0x30, to an unmapped address, or to another port's offsets changes no register. A read of an unmapped address returns 0.
- R8: For each pin n: when mode bit n is 1, `pad_out[n]` = output bit n and `pad_oe[n]` = output-enable bit n. When mode bit n is 0, the pad takes `alt_out[n]` and `alt_oe[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data; bits 15:8 are the pin enables on masked aliases |
| bus_rdata | output | 32 | Registered read data |
| alt_out | input | 8 | Alternate-function output value per pin |
| alt_oe | input | 8 | Alternate-function output enable per pin |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |

## Verification
Several properties are checked on every cycle: the per-pin pad selection between register state and alternate function, the zero upper read bits, the result of a masked write to the output register, the held state after a zero-enable masked write or a write to the input offset, and the exact two-cycle delay of the synchronizer. Some behaviour appears only in the bench's scenarios: that each offset reaches the intended register, that this port ignores another port's offsets, and that unmapped reads return zero. The same holds for alias readback and for the exact edge at which a pad change first becomes visible to a read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int PINS   = 8;
    localparam int DATA_W = 32;
    localparam int CTL_N  = 3;

    localparam int OFS_MODE = 'h00;
    localparam int OFS_OEN  = 'h10;
    localparam int OFS_OVAL = 'h20;
    localparam int OFS_INP  = 'h30;

    typedef logic [PINS-1:0] pin_vec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_OEN,
        SEL_OVAL,
        SEL_INP
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic masked;
    } hit_t;

    // Control register order: 0 mode, 1 output enable, 2 output value
    function automatic sel_e ctl_sel(input int idx);
        case (idx)
            0:       return SEL_MODE;
            1:       return SEL_OEN;
            default: return SEL_OVAL;
        endcase
    endfunction

    // Merge write data into a register: full load, or per-pin load under the upper-byte enables
    function automatic pin_vec_t apply_write(input pin_vec_t cur,
                                             input logic [DATA_W-1:0] wd,
                                             input logic masked);
        pin_vec_t en;
        en = masked ? wd[2*PINS-1:PINS] : '1;
        return (cur & ~en) | (wd[PINS-1:0] & en);
    endfunction
endpackage

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int PORT_IDX = 0,
    parameter int MASK_OFS = 'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    localparam int PBASE = PORT_IDX * 4;
    localparam int MBASE = MASK_OFS + PORT_IDX * 4;

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(PBASE + OFS_MODE);
    localparam logic [ADDR_W-1:0] A_OEN  = ADDR_W'(PBASE + OFS_OEN);
    localparam logic [ADDR_W-1:0] A_OVAL = ADDR_W'(PBASE + OFS_OVAL);
    localparam logic [ADDR_W-1:0] A_INP  = ADDR_W'(PBASE + OFS_INP);
    localparam logic [ADDR_W-1:0] M_MODE = ADDR_W'(MBASE + OFS_MODE);
    localparam logic [ADDR_W-1:0] M_OEN  = ADDR_W'(MBASE + OFS_OEN);
    localparam logic [ADDR_W-1:0] M_OVAL = ADDR_W'(MBASE + OFS_OVAL);

    always_comb begin
        hit.sel    = SEL_NONE;
        hit.masked = 1'b0;
        if (addr == A_MODE) begin
            hit.sel = SEL_MODE;
        end else if (addr == A_OEN) begin
            hit.sel = SEL_OEN;
        end else if (addr == A_OVAL) begin
            hit.sel = SEL_OVAL;
        end else if (addr == A_INP) begin
            hit.sel = SEL_INP;
        end else if (addr == M_MODE) begin
            hit.sel    = SEL_MODE;
            hit.masked = 1'b1;
        end else if (addr == M_OEN) begin
            hit.sel    = SEL_OEN;
            hit.masked = 1'b1;
        end else if (addr == M_OVAL) begin
            hit.sel    = SEL_OVAL;
            hit.masked = 1'b1;
        end
    end
endmodule

// File: rtl/gpx_pinreg.sv
module gpx_pinreg
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              masked,
    input  logic [DATA_W-1:0] wdata,
    output pin_vec_t          q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= apply_write(q, wdata, masked);
        end
    end
endmodule

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= d[b];
                stage2 <= stage1;
            end
        end
        assign q[b] = stage2;
    end
endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int PORT_IDX = 0,
    parameter int MASK_OFS = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        alt_out,
    input  logic [7:0]        alt_oe,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pad_out,
    output logic [7:0]        pad_oe
);
    hit_t              hit;
    pin_vec_t          ctl_q [CTL_N];
    pin_vec_t          mode_q, oen_q, oval_q, in_sync;
    logic [DATA_W-1:0] rd_mux;

    gpx_decode #(
        .ADDR_W  (ADDR_W),
        .PORT_IDX(PORT_IDX),
        .MASK_OFS(MASK_OFS)
    ) u_dec (
        .addr(bus_addr),
        .hit (hit)
    );

    for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
        logic wr_hit;
        assign wr_hit = bus_wr && (hit.sel == ctl_sel(g));
        gpx_pinreg u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_hit),
            .masked(hit.masked),
            .wdata (bus_wdata),
            .q     (ctl_q[g])
        );
    end

    assign mode_q = ctl_q[0];
    assign oen_q  = ctl_q[1];
    assign oval_q = ctl_q[2];

    gpx_sync #(.WIDTH(PINS)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pad_in),
        .q  (in_sync)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pad
        assign pad_out[p] = mode_q[p] ? oval_q[p] : alt_out[p];
        assign pad_oe[p]  = mode_q[p] ? oen_q[p]  : alt_oe[p];
    end

    always_comb begin
        rd_mux = '0;
        case (hit.sel)
            SEL_MODE: rd_mux[PINS-1:0] = mode_q;
            SEL_OEN:  rd_mux[PINS-1:0] = oen_q;
            SEL_OVAL: rd_mux[PINS-1:0] = oval_q;
            SEL_INP:  rd_mux[PINS-1:0] = in_sync;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk #(
    parameter int ADDR_W   = 12,
    parameter int PORT_IDX = 0,
    parameter int MASK_OFS = 'h80
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        alt_out,
    input logic [7:0]        alt_oe,
    input logic [7:0]        pad_in,
    input logic [7:0]        pad_out,
    input logic [7:0]        pad_oe,
    input logic [7:0]        mode_q,
    input logic [7:0]        oen_q,
    input logic [7:0]        oval_q,
    input logic [7:0]        in_sync
);
    localparam logic [ADDR_W-1:0] C_INP  = ADDR_W'(PORT_IDX * 4 + 'h30);
    localparam logic [ADDR_W-1:0] C_MMOD = ADDR_W'(MASK_OFS + PORT_IDX * 4);
    localparam logic [ADDR_W-1:0] C_MOEN = ADDR_W'(MASK_OFS + PORT_IDX * 4 + 'h10);
    localparam logic [ADDR_W-1:0] C_MOVL = ADDR_W'(MASK_OFS + PORT_IDX * 4 + 'h20);

    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    logic masked_hit;
    assign masked_hit = (bus_addr == C_MMOD) || (bus_addr == C_MOEN) || (bus_addr == C_MOVL);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == 8'h00 && oen_q == 8'h00 && oval_q == 8'h00 && bus_rdata == 32'h0));

    // R5
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:8] == 24'h0);

    // R8
    pad_oe_sel_chk: assert property (@(posedge clk) disable iff (rst)
        pad_oe == ((mode_q & oen_q) | (~mode_q & alt_oe)));

    // R8
    pad_out_sel_chk: assert property (@(posedge clk) disable iff (rst)
        pad_out == ((mode_q & oval_q) | (~mode_q & alt_out)));

    // R3
    masked_oval_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == C_MOVL) |=>
        oval_q == (($past(oval_q) & ~$past(bus_wdata[15:8])) |
                   ($past(bus_wdata[7:0]) & $past(bus_wdata[15:8]))));

    // R4
    zero_mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && masked_hit && bus_wdata[15:8] == 8'h00) |=>
        ($stable(mode_q) && $stable(oen_q) && $stable(oval_q)));

    // R7
    inp_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == C_INP) |=>
        ($stable(mode_q) && $stable(oen_q) && $stable(oval_q)));

    // R6
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> in_sync == $past(pad_in, 2));
endmodule

bind gpx_port gpx_port_chk #(
    .ADDR_W  (ADDR_W),
    .PORT_IDX(PORT_IDX),
    .MASK_OFS(MASK_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .alt_out  (alt_out),
    .alt_oe   (alt_oe),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .mode_q   (mode_q),
    .oen_q    (oen_q),
    .oval_q   (oval_q),
    .in_sync  (in_sync)
);

// File: tb/sim_gpx_port.sv
module sim_gpx_port;
    localparam int ADDR_W   = 12;
    localparam int PORT_IDX = 2;
    localparam int MASK_OFS = 'h80;

    localparam logic [11:0] A_MODE = 12'h008;
    localparam logic [11:0] A_OEN  = 12'h018;
    localparam logic [11:0] A_OVAL = 12'h028;
    localparam logic [11:0] A_INP  = 12'h038;
    localparam logic [11:0] M_MODE = 12'h088;
    localparam logic [11:0] M_OEN  = 12'h098;
    localparam logic [11:0] M_OVAL = 12'h0A8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [7:0]        alt_out = 8'h5A;
    logic [7:0]        alt_oe = 8'hC3;
    logic [7:0]        pad_in = 8'h00;
    logic [7:0]        pad_out, pad_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #10 clk = ~clk;

    gpx_port #(
        .ADDR_W  (ADDR_W),
        .PORT_IDX(PORT_IDX),
        .MASK_OFS(MASK_OFS)
    ) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Monitor: pops the expected value for each read once the data is captured
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read with no expected item, act=%h exp=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: read act=%h exp=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_pads(input logic [7:0] eo, input logic [7:0] ee, input string t);
        n_tests++;
        if (pad_out !== eo || pad_oe !== ee) begin
            n_fail++;
            $display("FAIL %s: pads act out=%h oe=%h exp out=%h oe=%h", t, pad_out, pad_oe, eo, ee);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: act=timeout exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, pads under alternate function
        do_read(A_MODE, 32'h0, "R1 mode");
        do_read(A_OEN,  32'h0, "R1 oen");
        do_read(A_OVAL, 32'h0, "R1 oval");
        check_pads(8'h5A, 8'hC3, "R1 R8 alt pads");

        // R2: plain load, upper bits ignored
        bus_write(A_OVAL, 32'hFFFF_FF3C);
        do_read(A_OVAL, 32'h0000_003C, "R2 oval");

        // R3: masked merge (3C & 0F) | (A5 & F0) = AC
        bus_write(M_OVAL, 32'h0000_F0A5);
        do_read(A_OVAL, 32'h0000_00AC, "R3 oval merge");
        // R5: alias reads the same register
        do_read(M_OVAL, 32'h0000_00AC, "R5 alias read");

        // R4: zero enables change nothing
        bus_write(M_OVAL, 32'h0000_00FF);
        do_read(A_OVAL, 32'h0000_00AC, "R4 zero mask");

        // R8: mode 0F, oen 33, oval AC, alt 5A/C3
        bus_write(M_MODE, 32'h0000_0F0F);
        bus_write(A_OEN,  32'h0000_0033);
        check_pads(8'h5C, 8'hC3, "R8 mixed pads");
        do_read(A_MODE, 32'h0000_000F, "R3 mode masked");

        // R3: single pin clear of output enable
        bus_write(M_OEN, 32'h0000_0180);
        do_read(A_OEN, 32'h0000_0032, "R3 oen bit0");
        check_pads(8'h5C, 8'hC2, "R8 after oen change");

        // R7: input offset, other port, unmapped
        bus_write(A_INP, 32'h0000_00FF);
        bus_write(12'h000, 32'h0000_00FF);
        bus_write(12'h004, 32'h0000_FFFF);
        do_read(A_MODE, 32'h0000_000F, "R7 mode kept");
        do_read(A_OEN,  32'h0000_0032, "R7 oen kept");
        do_read(A_OVAL, 32'h0000_00AC, "R7 oval kept");
        do_read(12'h004, 32'h0, "R7 unmapped read");
        do_read(12'h010, 32'h0, "R7 other port read");

        // R6: pad change seen on the third captured read
        pad_in = 8'h96;
        do_read(A_INP, 32'h0, "R6 edge k");
        do_read(A_INP, 32'h0, "R6 edge k+1");
        do_read(A_INP, 32'h0000_0096, "R6 edge k+2");

        // R8: all pins to software
        bus_write(M_MODE, 32'h0000_F0F0);
        check_pads(8'hAC, 8'h32, "R8 all gpio");

        // R1: reset again mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_pads(8'h5A, 8'hC3, "R1 pads after reset");
        do_read(A_MODE, 32'h0, "R1 mode after reset");
        do_read(A_OVAL, 32'h0, "R1 oval after reset");

        repeat (2) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: pending act=%0d exp=0", exp_q.size());
        end
        finish_run();
    end
endmodule